// File: doc/BRIEF.md
# Stack Call Return Unit

This block owns the stack pointer of a small CPU and runs the memory traffic behind subroutine calls, returns, pushes and pops. Decode hands it one operation at a time, together with the return PC (already advanced past the calling instruction), a branch target, a register value, and an effective address that was computed upstream for the memory form of push. The unit lowers or raises the pointer in steps of four and issues at most one word access per operation on a single-port memory request interface. It then reports the outcome: a new PC for call and return, popped data with a write strobe for the register file, and the updated pointer.

Every result is registered. While a memory access is outstanding, `busy` is high and new operations are refused. A one-cycle `done` pulse marks the end of each operation. A separate operation loads a thread's own stack bottom into the pointer when the thread starts.

Top module: `stack_sequencer`

## Requirements
- R1: After reset, `sp_out` is 0, and `busy`, `done`, `mem_req`, `pc_load` and `pop_we` are all low.
- R2: Operation code 7 (set pointer) loads `init_sp` into the pointer and pulses `done` on the next cycle, with no memory access.
- R3: Operation code 1 (call) first lowers the pointer by 4, then writes `cur_pc` at the new pointer. When the write completes, `pc_load` pulses and `pc_out` equals `target`.
- R4: Operation code 2 (return) reads the word at the current pointer. When the read completes, `pc_load` pulses with `pc_out` equal to that word, and the pointer rises by 4.
- R5: Operation code 3 (register push) lowers the pointer by 4, then writes `push_val` at the new pointer.
- R6: Operation code 4 (address push) lowers the pointer by 4, then writes the value of `eff_addr` itself at the new pointer. It makes exactly one access, a write, and never reads.
- R7: Operation code 5 (register pop) reads the word at the current pointer. When the read completes, `pop_we` pulses with `pop_data` equal to that word, and the pointer rises by 4.
- R8: Operation code 6 (drop) raises the pointer by 4 and pulses `done` on the next cycle, with no memory access and no `pop_we`.
- R9: `busy` stays high from the cycle after a memory operation is accepted until the cycle in which `done` pulses. An operation offered while `busy` is high changes neither the pointer nor the memory.
- R10: While `mem_req` is high and `mem_ready` is low, the request and its address, write enable and write data stay unchanged.
- R11: Across any mixed sequence of operations, the pointer, the memory contents, the returned PC and the popped data match a step-by-step stack model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 3 | Operation selector (codes listed in the requirements) |
| cur_pc | input | W | Return PC, already advanced past the call |
| target | input | W | Call target address |
| push_val | input | W | Register value for a register push |
| eff_addr | input | W | Computed effective address for an address push |
| init_sp | input | W | Stack bottom for the set-pointer operation |
| busy | output | 1 | A memory access is outstanding |
| done | output | 1 | One-cycle pulse at the end of an operation |
| sp_out | output | W | Current stack pointer |
| pc_load | output | 1 | One-cycle pulse: load `pc_out` into the PC |
| pc_out | output | W | New PC for call and return |
| pop_we | output | 1 | One-cycle pulse: write `pop_data` to the register |
| pop_data | output | W | Word read by a register pop |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Request address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the request this cycle |

## Verification
The bench pairs each call with a return and checks that the return brings back the advanced PC. A unit that wrote at the old pointer, or that raised the pointer before reading, would hand back a neighbouring word. An address push followed by a register pop must return the address itself; a unit that fetched through that address would return memory contents instead. A drop must leave the access count unchanged, which exposes a unit that performs a needless read. Stalls of varying length, with a set-pointer operation offered in the middle, show whether the unit drops a request early or lets the intruding operation overwrite the pointer.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [2:0] {
    SOP_NONE  = 3'd0,
    SOP_CALL  = 3'd1,
    SOP_RET   = 3'd2,
    SOP_PUSHR = 3'd3,
    SOP_PUSHA = 3'd4,
    SOP_POPR  = 3'd5,
    SOP_POPD  = 3'd6,
    SOP_SETSP = 3'd7
  } sop_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} sst_e;
endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int W = 16,
  parameter int STEP_BYTES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] sp
);
  localparam logic [W-1:0] STEP = W'(STEP_BYTES);

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (load) sp <= load_val;
    else if (dec)  sp <= sp - STEP;
    else if (inc)  sp <= sp + STEP;
  end

  assert_one_update_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec, inc, load}));
endmodule

// File: rtl/stack_mem_port.sv
module stack_mem_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         start_we,
  input  logic [W-1:0] start_addr,
  input  logic [W-1:0] start_wdata,
  input  logic         mem_ready,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         complete
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end else if (mem_req && mem_ready) begin
      mem_req <= 1'b0;
    end
  end

  assign complete = mem_req & mem_ready;

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !mem_req);
endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
  import stack_pkg::*;
#(
  parameter int W = 16,
  parameter int STEP_BYTES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] target,
  input  logic [W-1:0] push_val,
  input  logic [W-1:0] eff_addr,
  input  logic [W-1:0] init_sp,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sp_out,
  output logic         pc_load,
  output logic [W-1:0] pc_out,
  output logic         pop_we,
  output logic [W-1:0] pop_data,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready
);
  localparam logic [W-1:0] STEP = W'(STEP_BYTES);

  sst_e         state;
  sop_e         op_in, op_q;
  logic [W-1:0] tgt_q;
  logic         accept, complete;
  logic         sp_dec, sp_inc, sp_load;
  logic         m_start, m_we;
  logic [W-1:0] m_addr, m_wdata;

  assign op_in  = sop_e'(op_code);
  assign accept = op_valid && (state == ST_IDLE) && !rst;

  stack_ptr_reg #(.W(W), .STEP_BYTES(STEP_BYTES)) u_ptr (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .load(sp_load),
    .load_val(init_sp), .sp(sp_out));

  stack_mem_port #(.W(W)) u_mem (
    .clk(clk), .rst(rst), .start(m_start), .start_we(m_we),
    .start_addr(m_addr), .start_wdata(m_wdata), .mem_ready(mem_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .complete(complete));

  always_comb begin
    sp_dec  = 1'b0;
    sp_inc  = 1'b0;
    sp_load = 1'b0;
    m_start = 1'b0;
    m_we    = 1'b0;
    m_addr  = sp_out;
    m_wdata = '0;
    if (accept) begin
      case (op_in)
        SOP_CALL:  begin sp_dec = 1'b1; m_start = 1'b1; m_we = 1'b1;
                         m_addr = sp_out - STEP; m_wdata = cur_pc; end
        SOP_PUSHR: begin sp_dec = 1'b1; m_start = 1'b1; m_we = 1'b1;
                         m_addr = sp_out - STEP; m_wdata = push_val; end
        SOP_PUSHA: begin sp_dec = 1'b1; m_start = 1'b1; m_we = 1'b1;
                         m_addr = sp_out - STEP; m_wdata = eff_addr; end
        SOP_RET, SOP_POPR: m_start = 1'b1;
        SOP_POPD:  sp_inc  = 1'b1;
        SOP_SETSP: sp_load = 1'b1;
        default: ;
      endcase
    end else if (state == ST_WAIT && complete && (op_q == SOP_RET || op_q == SOP_POPR)) begin
      sp_inc = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= SOP_NONE;
      tgt_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      pc_load  <= 1'b0;
      pc_out   <= '0;
      pop_we   <= 1'b0;
      pop_data <= '0;
    end else begin
      done    <= 1'b0;
      pc_load <= 1'b0;
      pop_we  <= 1'b0;
      if (accept) begin
        op_q  <= op_in;
        tgt_q <= target;
        if (m_start) begin
          state <= ST_WAIT;
          busy  <= 1'b1;
        end else begin
          done <= 1'b1;
        end
      end else if (state == ST_WAIT && complete) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
        done  <= 1'b1;
        case (op_q)
          SOP_CALL: begin pc_load <= 1'b1; pc_out <= tgt_q; end
          SOP_RET:  begin pc_load <= 1'b1; pc_out <= mem_rdata; end
          SOP_POPR: begin pop_we <= 1'b1; pop_data <= mem_rdata; end
          default: ;
        endcase
      end
    end
  end

  assert_call_predec_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == SOP_CALL) |=> (sp_out == $past(sp_out) - STEP && mem_req && mem_we
      && mem_addr == sp_out && mem_wdata == $past(cur_pc)));

  assert_ret_read_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == SOP_RET) |=> (mem_req && !mem_we && mem_addr == $past(sp_out)
      && sp_out == $past(sp_out)));

  assert_push_ea_R6: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == SOP_PUSHA) |=> (mem_req && mem_we && mem_wdata == $past(eff_addr)));

  assert_drop_nomem_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && op_in == SOP_POPD) |=> (!mem_req && done && !pop_we && sp_out == $past(sp_out) + STEP));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  assert_done_free_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pc_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    (pc_load || pop_we) |-> done);
endmodule

// File: tb/stack_sequencer_test.sv
module stack_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_code = 3'd0;
  logic [W-1:0] cur_pc = '0, target = '0, push_val = '0, eff_addr = '0, init_sp = '0;
  logic         busy, done, pc_load, pop_we, mem_req, mem_we;
  logic [W-1:0] sp_out, pc_out, pop_data, mem_addr, mem_wdata, mem_rdata;
  logic         mem_ready = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  int lat_left = 0, acc_cnt = 0;
  logic          last_we;
  logic [W-1:0]  last_addr, last_wdata;
  logic [W-1:0]  bmem [64];
  logic [W-1:0]  refm [64];
  logic [W-1:0]  sp_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_sequencer #(.W(W)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .cur_pc(cur_pc),
    .target(target), .push_val(push_val), .eff_addr(eff_addr), .init_sp(init_sp),
    .busy(busy), .done(done), .sp_out(sp_out), .pc_load(pc_load), .pc_out(pc_out),
    .pop_we(pop_we), .pop_data(pop_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  assign mem_rdata = bmem[mem_addr[7:2]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req && mem_ready) begin
      acc_cnt    <= acc_cnt + 1;
      last_we    <= mem_we;
      last_addr  <= mem_addr;
      last_wdata <= mem_wdata;
      if (mem_we) bmem[mem_addr[7:2]] <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      if (lat_left == 0) mem_ready = 1'b1;
      else lat_left = lat_left - 1;
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [W-1:0] exp_sp(input logic [2:0] op, input logic [W-1:0] sp,
                                          input logic [W-1:0] ini);
    case (op)
      3'd1, 3'd3, 3'd4: return sp - 16'd4;
      3'd2, 3'd5, 3'd6: return sp + 16'd4;
      3'd7: return ini;
      default: return sp;
    endcase
  endfunction

  function automatic int exp_acc(input logic [2:0] op);
    return (op >= 3'd1 && op <= 3'd5) ? 1 : 0;
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [W-1:0] pc, input logic [W-1:0] tgt,
                       input logic [W-1:0] val, input logic [W-1:0] ea, input logic [W-1:0] ini,
                       input int lat, input bit intrude);
    string tg;
    int a0, n;
    logic [W-1:0] nsp, rd, wv;
    tg  = tag_of(op);
    a0  = acc_cnt;
    nsp = exp_sp(op, sp_m, ini);
    rd  = refm[sp_m[7:2]];
    wv  = (op == 3'd1) ? pc : (op == 3'd3) ? val : ea;
    lat_left = lat;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; cur_pc = pc; target = tgt;
    push_val = val; eff_addr = ea; init_sp = ini;
    @(negedge clk);
    op_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (intrude && n == 0) begin
        chk(busy == 1'b1, "R9", busy, 1);
        op_valid = 1'b1; op_code = 3'd7; init_sp = 16'h0010;
      end else begin
        op_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    op_valid = 1'b0;
    chk(done == 1'b1, tg, done, 1);
    chk(sp_out == nsp, tg, sp_out, nsp);
    chk(acc_cnt - a0 == exp_acc(op), tg, acc_cnt - a0, exp_acc(op));
    if (op == 3'd1 || op == 3'd3 || op == 3'd4) begin
      chk(last_we == 1'b1 && last_addr == nsp, tg, last_addr, nsp);
      chk(last_wdata == wv, tg, last_wdata, wv);
      refm[nsp[7:2]] = wv;
    end
    if (op == 3'd2 || op == 3'd5)
      chk(last_we == 1'b0 && last_addr == sp_m, tg, last_addr, sp_m);
    if (op == 3'd1) chk(pc_load && pc_out == tgt, tg, pc_out, tgt);
    if (op == 3'd2) chk(pc_load && pc_out == rd, tg, pc_out, rd);
    if (op == 3'd5) chk(pop_we && pop_data == rd, tg, pop_data, rd);
    if (op != 3'd5) chk(pop_we == 1'b0, tg, pop_we, 0);
    if (op != 3'd1 && op != 3'd2) chk(pc_load == 1'b0, tg, pc_load, 0);
    if (intrude) chk(sp_out == nsp, "R9", sp_out, nsp);
    sp_m = nsp;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 16'hA000 + 16'(i);
      refm[i] = 16'hA000 + 16'(i);
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sp_out == 0 && !busy && !done && !mem_req && !pc_load && !pop_we, "R1", sp_out, 0);

    do_op(3'd7, 0, 0, 0, 0, 16'h00F0, 0, 0);                      // R2
    do_op(3'd1, 16'h0123, 16'h0400, 0, 0, 0, 2, 0);               // R3
    do_op(3'd2, 0, 0, 0, 0, 0, 0, 0);                             // R4 returns 0x0123
    chk(pc_out == 16'h0123, "R4", pc_out, 16'h0123);
    do_op(3'd3, 0, 0, 16'hBEEF, 0, 0, 1, 0);                      // R5
    do_op(3'd4, 0, 0, 0, 16'h0ABC, 0, 3, 0);                      // R6
    do_op(3'd5, 0, 0, 0, 0, 0, 0, 0);                             // R7 pops 0x0ABC
    chk(pop_data == 16'h0ABC, "R6", pop_data, 16'h0ABC);
    do_op(3'd5, 0, 0, 0, 0, 0, 2, 0);                             // R7 pops 0xBEEF
    chk(pop_data == 16'hBEEF, "R7", pop_data, 16'hBEEF);
    do_op(3'd6, 0, 0, 0, 0, 0, 0, 0);                             // R8
    do_op(3'd1, 16'h0777, 16'h0200, 0, 0, 0, 4, 1);               // R9 intrusion
    do_op(3'd2, 0, 0, 0, 0, 0, 3, 1);                             // R9, R10 stall
    chk(pc_out == 16'h0777, "R10", pc_out, 16'h0777);

    for (int k = 0; k < 300; k++) begin                           // R11 random mix
      logic [2:0] op;
      if (sp_m >= 16'h00F0)      op = 3'd1 + 3'($urandom % 3);
      else if (sp_m <= 16'h0044) op = 3'd1 + 3'(($urandom % 2) * 2);
      else                       op = 3'd1 + 3'($urandom % 6);
      do_op(op, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 0,
            int'($urandom % 4), bit'($urandom % 5 == 0));
    end
    do_op(3'd7, 0, 0, 0, 0, 16'h0080, 0, 0);                      // R2 reload
    chk(sp_out == 16'h0080, "R11", sp_out, 16'h0080);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below 150000", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule